// File: doc/BRIEF.md
# Charging Port Mode Selector and Power Sequencer

This block serves the downstream ports of a hub. For each port it picks a battery-charging mode from four things: that port's charging enable, a comparator flag that says VBUS is above the 4 V threshold, a global bit that turns automatic charging off, and whether the upstream port is connected. The chosen mode is reported as a 2-bit code per port. A per-port flag also reports whether a divider-mode port advertises the high-current (10 W) level instead of the default 5 W level.

The block also drives the power-switch enable lines. They can work per port or as one ganged line, and they can be active high or active low. Each time a port's wanted mode changes, the port's power is removed at once. Power stays off for a gap of (step+1) units of `STEP_TICKS` millisecond ticks, where step is a 3-bit field; with the default `STEP_TICKS` = 200 one unit is 200 ms. When the gap ends, the new mode code is published and power returns in the same cycle. If the wanted mode changes again during a gap, the gap starts over. Automatic mode never detects the attached device, so in this block it always reports divider mode.

All of these are plain control and status pins. None of them carries a data stream, so there is no valid/ready handshake and no back-pressure.

Top module: `charge_port_sequencer`

## Requirements
- R1: A port whose charging enable is 0 settles to mode code 0 (none).
- R2: With its enable at 1, upstream not connected and its VBUS flag at 1, a port settles to code 1 (CDP).
- R3: With its enable at 1, upstream not connected and its VBUS flag at 0, a port settles to code 3 (divider, the automatic mode) when the auto-disable bit is 0, and to code 2 (DCP) when it is 1.
- R4: With upstream connected, every enabled port settles to code 1 (CDP). The exception is port index 0, which settles to code 0 while the auto-disable bit is 0.
- R5: When a port's wanted mode changes, that port's logical power goes off after the clock edge that samples the change. Power then stays off for exactly (gap_step+1)*STEP_TICKS ms_tick pulses, counted at later edges. The mode output keeps the old code until the same edge that restores power.
- R6: A change in the wanted mode during a pending gap restarts the full gap from zero, and the last wanted mode is the one published.
- R7: With pol_high at 1, a high level on a power line means power on. With pol_high at 0, a low level means power on.
- R8: When full power management is on (pm_off = 0) and gang_sel = 1, line 0 is on only while no port has a pending gap, and lines 1 and up are held at the off level.
- R9: Otherwise each line i follows the power of port i alone.
- R10: div_hicur[i] is 1 exactly when port i reports code 3 and hicur_en is 1.
- R11: After reset every mode code is 0, no gap is pending, and every line is at the on level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| chg_en | input | NUM_PORTS | Per-port charging enable |
| vbus_hi | input | NUM_PORTS | Per-port VBUS above 4 V flag |
| auto_dis | input | 1 | 1 turns automatic charging mode off |
| host_conn | input | 1 | Upstream port connected |
| hicur_en | input | 1 | Divider mode advertises high current |
| pol_high | input | 1 | 1 = power lines active high, 0 = active low |
| pm_off | input | 1 | 1 = full power management disabled |
| gang_sel | input | 1 | Ganged power switching request |
| gap_step | input | 3 | Power-off gap length in units of STEP_TICKS ticks, minus one |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| port_mode | output | 2*NUM_PORTS | Published mode code per port, port i at bits [2i+1:2i] |
| div_hicur | output | NUM_PORTS | Per-port high-current divider advertisement |
| pwr_ctl | output | NUM_PORTS | Power-switch enable lines |

## Verification
The wanted mode is decoded without registers. It is captured at the clock edge after the inputs change, and the power lines leave the on level right after that edge. The mode codes and div_hicur change only at the edge that takes the last counted tick. A polarity or gang change moves the lines in the same cycle. The bench changes inputs 2 ns after a rising edge and keeps a behavioural model that it updates at each rising edge. It compares every output with that model at the falling edge, so each result is checked in the first cycle it is due. Directed checks count gap ticks directly from the observed line levels.

// File: rtl/chgseq_pkg.sv
package chgseq_pkg;
  typedef enum logic [1:0] {
    CM_NONE = 2'd0,
    CM_CDP  = 2'd1,
    CM_DCP  = 2'd2,
    CM_DIV  = 2'd3
  } chg_mode_t;
endpackage

// File: rtl/chgseq_decode.sv
module chgseq_decode
  import chgseq_pkg::*;
#(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0]      chg_en,
  input  logic [NUM_PORTS-1:0]      vbus_hi,
  input  logic                      auto_dis,
  input  logic                      host_conn,
  output logic [NUM_PORTS-1:0][1:0] want
);
  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_dec
    localparam bit FIRST_PORT = (g == 0);
    chg_mode_t m;
    always_comb begin
      if (!chg_en[g]) begin
        m = CM_NONE;
      end else if (host_conn) begin
        // connected host: CDP everywhere except the first port under auto mode
        m = (FIRST_PORT && !auto_dis) ? CM_NONE : CM_CDP;
      end else if (vbus_hi[g]) begin
        m = CM_CDP;
      end else begin
        m = auto_dis ? CM_DCP : CM_DIV;
      end
    end
    assign want[g] = m;
  end
endmodule

// File: rtl/chgseq_port.sv
module chgseq_port
  import chgseq_pkg::*;
#(
  parameter int LIM_W = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       want,
  input  logic             ms_tick,
  input  logic [LIM_W-1:0] lim,
  output logic [1:0]       mode,
  output logic             busy
);
  logic [1:0]       pend_q;
  logic [1:0]       mode_q;
  logic             busy_q;
  logic [LIM_W-1:0] cnt_q;
  logic             last_tick;

  assign last_tick = ms_tick && (cnt_q >= lim - LIM_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= CM_NONE;
      mode_q <= CM_NONE;
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (want != pend_q) begin
      pend_q <= want;
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q && ms_tick) begin
      if (last_tick) begin
        busy_q <= 1'b0;
        mode_q <= pend_q;
      end else begin
        cnt_q <= cnt_q + LIM_W'(1);
      end
    end
  end

  assign mode = mode_q;
  assign busy = busy_q;

  a_r5_mode_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != $past(mode_q)) |-> ($past(busy_q) && !busy_q));

  a_r6_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (want != pend_q) |=> (busy_q && cnt_q == '0));

  a_r5_done_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_q) |-> $past(ms_tick));
endmodule

// File: rtl/chgseq_drive.sv
module chgseq_drive #(
  parameter int NUM_PORTS = 4
) (
  input  logic [NUM_PORTS-1:0] port_on,
  input  logic                 pol_high,
  input  logic                 gang_act,
  output logic [NUM_PORTS-1:0] pwr_ctl
);
  logic [NUM_PORTS-1:0] on_eff;
  logic                 all_on;

  assign all_on = &port_on;

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_drv
    if (g == 0) begin : g_lead
      assign on_eff[g] = gang_act ? all_on : port_on[g];
    end else begin : g_rest
      assign on_eff[g] = gang_act ? 1'b0 : port_on[g];
    end
    assign pwr_ctl[g] = pol_high ? on_eff[g] : ~on_eff[g];
  end
endmodule

// File: rtl/charge_port_sequencer.sv
module charge_port_sequencer
  import chgseq_pkg::*;
#(
  parameter int NUM_PORTS  = 4,
  parameter int STEP_W     = 3,
  parameter int STEP_TICKS = 200
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NUM_PORTS-1:0]   chg_en,
  input  logic [NUM_PORTS-1:0]   vbus_hi,
  input  logic                   auto_dis,
  input  logic                   host_conn,
  input  logic                   hicur_en,
  input  logic                   pol_high,
  input  logic                   pm_off,
  input  logic                   gang_sel,
  input  logic [STEP_W-1:0]      gap_step,
  input  logic                   ms_tick,
  output logic [2*NUM_PORTS-1:0] port_mode,
  output logic [NUM_PORTS-1:0]   div_hicur,
  output logic [NUM_PORTS-1:0]   pwr_ctl
);
  localparam int MAX_GAP = (1 << STEP_W) * STEP_TICKS;
  localparam int LIM_W   = $clog2(MAX_GAP + 1);

  logic [NUM_PORTS-1:0][1:0] want;
  logic [NUM_PORTS-1:0]      busy;
  logic [NUM_PORTS-1:0]      port_on;
  logic [LIM_W-1:0]          lim;
  logic                      gang_act;

  assign lim      = LIM_W'((32'(gap_step) + 32'd1) * 32'(STEP_TICKS));
  assign gang_act = !pm_off && gang_sel;

  chgseq_decode #(.NUM_PORTS(NUM_PORTS)) u_dec (
    .chg_en    (chg_en),
    .vbus_hi   (vbus_hi),
    .auto_dis  (auto_dis),
    .host_conn (host_conn),
    .want      (want)
  );

  for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
    logic [1:0] mode;
    chgseq_port #(.LIM_W(LIM_W)) u_port (
      .clk     (clk),
      .rst_n   (rst_n),
      .want    (want[g]),
      .ms_tick (ms_tick),
      .lim     (lim),
      .mode    (mode),
      .busy    (busy[g])
    );
    assign port_mode[2*g +: 2] = mode;
    assign div_hicur[g]        = hicur_en && (mode == CM_DIV);
    assign port_on[g]          = !busy[g];

    a_r5_off_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (busy[g] && !gang_act) |-> (pwr_ctl[g] == ~pol_high));
  end

  chgseq_drive #(.NUM_PORTS(NUM_PORTS)) u_drv (
    .port_on  (port_on),
    .pol_high (pol_high),
    .gang_act (gang_act),
    .pwr_ctl  (pwr_ctl)
  );

  a_r8_gang_lead_off: assert property (@(posedge clk) disable iff (!rst_n)
    (gang_act && (|busy)) |-> (pwr_ctl[0] == ~pol_high));

  a_r10_hicur_needs_div: assert property (@(posedge clk) disable iff (!rst_n)
    (|div_hicur) |-> hicur_en);
endmodule

// File: tb/charge_port_sequencer_tb.sv
module charge_port_sequencer_tb;
  localparam int N  = 4;
  localparam int ST = 200;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [N-1:0] chg_en = '0, vbus_hi = '0;
  logic         auto_dis = 1'b0, host_conn = 1'b0, hicur_en = 1'b0;
  logic         pol_high = 1'b1, pm_off = 1'b1, gang_sel = 1'b0;
  logic [2:0]   gap_step = 3'd0;
  logic         ms_tick = 1'b0;
  logic [2*N-1:0] port_mode;
  logic [N-1:0] div_hicur, pwr_ctl;

  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  charge_port_sequencer #(.NUM_PORTS(N), .STEP_W(3), .STEP_TICKS(ST)) u_dut (
    .clk(clk), .rst_n(rst_n), .chg_en(chg_en), .vbus_hi(vbus_hi),
    .auto_dis(auto_dis), .host_conn(host_conn), .hicur_en(hicur_en),
    .pol_high(pol_high), .pm_off(pm_off), .gang_sel(gang_sel),
    .gap_step(gap_step), .ms_tick(ms_tick), .port_mode(port_mode),
    .div_hicur(div_hicur), .pwr_ctl(pwr_ctl)
  );

  // tick generator: one pulse every 4 cycles, changed 2 ns after the edge
  int tdiv = 0;
  always @(posedge clk) begin
    #2;
    tdiv = (tdiv + 1) % 4;
    ms_tick = (tdiv == 0);
  end

  // behavioural reference model
  int m_cur[N], m_pend[N], m_cnt[N];
  bit m_busy[N];

  function automatic int want_of(int p);
    if (!chg_en[p]) return 0;
    if (host_conn) return (p == 0 && !auto_dis) ? 0 : 1;
    if (vbus_hi[p]) return 1;
    return auto_dis ? 2 : 3;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < N; p++) begin
        m_cur[p] = 0; m_pend[p] = 0; m_cnt[p] = 0; m_busy[p] = 0;
      end
    end else begin
      for (int p = 0; p < N; p++) begin
        int w;
        w = want_of(p);
        if (w != m_pend[p]) begin
          m_pend[p] = w; m_busy[p] = 1; m_cnt[p] = 0;
        end else if (m_busy[p] && ms_tick) begin
          m_cnt[p]++;
          if (m_cnt[p] >= (int'(gap_step) + 1) * ST) begin
            m_busy[p] = 0; m_cur[p] = m_pend[p];
          end
        end
      end
    end
  end

  task automatic chk(string tag, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      bit gang, all_on;
      gang = !pm_off && gang_sel;
      all_on = 1;
      for (int p = 0; p < N; p++) if (m_busy[p]) all_on = 0;
      for (int p = 0; p < N; p++) begin
        bit on;
        int exp_line;
        on = gang ? ((p == 0) ? all_on : 1'b0) : !m_busy[p];
        exp_line = pol_high ? on : !on;
        chk("R5 mode", int'(port_mode[2*p +: 2]), m_cur[p]);
        chk(gang ? "R8 line" : "R9 line", int'(pwr_ctl[p]), exp_line);
        chk("R10 hicur", int'(div_hicur[p]), int'(hicur_en && m_cur[p] == 3));
      end
    end
  end

  // gap measurement on one line
  int meas_port = 0, meas_cnt = 0;
  bit meas_on = 0, off_flag = 0;
  always @(negedge clk) off_flag = (pwr_ctl[meas_port] == ~pol_high);
  always @(posedge clk) if (meas_on && ms_tick && off_flag) meas_cnt++;

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  function automatic int md(int p);
    return int'(port_mode[2*p +: 2]);
  endfunction

  task automatic finish_run();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    cyc(4);
    rst_n = 1'b1;
    cyc(1);
    at_neg();
    chk("R11 modes", int'(port_mode), 0);
    chk("R11 lines", int'(pwr_ctl), 4'hF);

    // R2/R3/R5: port0 VBUS high, others low, auto on
    cyc(1);
    meas_port = 0; meas_cnt = 0; meas_on = 1;
    chg_en = 4'hF; vbus_hi = 4'b0001;
    cyc(1); at_neg();
    chk("R5 power off at once", int'(pwr_ctl), 4'h0);
    chk("R5 mode held", int'(port_mode), 0);
    cyc(1000); at_neg();
    meas_on = 0;
    chk("R5 gap ticks step0", meas_cnt, 200);
    chk("R2 cdp", md(0), 1);
    chk("R3 divider", md(1), 3);
    chk("R3 divider p3", md(3), 3);

    // R10: high current
    cyc(1); hicur_en = 1; cyc(1); at_neg();
    chk("R10 hicur flags", int'(div_hicur), 4'b1110);

    // R3: auto disabled -> DCP
    cyc(1); auto_dis = 1; cyc(1000); at_neg();
    chk("R3 dcp", md(2), 2);
    chk("R2 cdp kept", md(0), 1);
    chk("R10 hicur cleared", int'(div_hicur), 0);

    // R4: host connected, auto on
    cyc(1); host_conn = 1; auto_dis = 0; cyc(1000); at_neg();
    chk("R4 first port none", md(0), 0);
    chk("R4 cdp others", md(1), 1);
    cyc(1); auto_dis = 1; cyc(1000); at_neg();
    chk("R4 first port cdp", md(0), 1);

    // R1 with a longer gap measured on port 1
    cyc(1); gap_step = 3'd2; meas_port = 1; meas_cnt = 0; meas_on = 1;
    chg_en = 4'h0;
    cyc(2600); at_neg();
    meas_on = 0;
    chk("R5 gap ticks step2", meas_cnt, 600);
    chk("R1 disabled", int'(port_mode), 0);

    // R6: restart during a pending gap
    cyc(1); gap_step = 3'd1; chg_en = 4'b0100;
    cyc(200); host_conn = 0; vbus_hi = 4'b0000;
    cyc(1500); at_neg();
    chk("R6 still pending mode", md(2), 0);
    chk("R6 still pending line", int'(pwr_ctl[2]), 0);
    cyc(400); at_neg();
    chk("R6 last mode wins", md(2), 2);

    // R7: active-low lines
    cyc(1); pol_high = 0; cyc(1); at_neg();
    chk("R7 active low idle", int'(pwr_ctl), 4'h0);
    cyc(1); pol_high = 1;

    // R8: ganged
    pm_off = 0; gang_sel = 1; gap_step = 3'd0;
    cyc(1); at_neg();
    chk("R8 settled gang", int'(pwr_ctl), 4'b0001);
    cyc(1); chg_en = 4'b1100; cyc(10); at_neg();
    chk("R8 gang off", int'(pwr_ctl), 4'b0000);
    cyc(900); at_neg();
    chk("R8 gang back", int'(pwr_ctl), 4'b0001);

    // R9: full management off -> per port even with gang_sel
    cyc(1); pm_off = 1; cyc(1); at_neg();
    chk("R9 per port idle", int'(pwr_ctl), 4'hF);
    cyc(1); chg_en = 4'b1110; cyc(10); at_neg();
    chk("R9 only port1 off", int'(pwr_ctl), 4'b1101);
    cyc(900); at_neg();
    chk("R9 port1 back", int'(pwr_ctl), 4'hF);

    finish_run();
  end
endmodule